// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a three-wire serial EEPROM that uses a select line, a shift clock, a serial command line into the memory and a serial data line out of it. A single-cycle request with an 8-bit word address starts a fixed sequence. The sequence gives one idle clock with the select line high, then sends a start bit, the read opcode and the address. It then clocks in sixteen data bits and ends with a short deselect-and-clock pattern. When the sequence ends, the block raises a one-cycle completion strobe and the word is valid.

Every change on the three driven lines is held for a run-time-programmable number of system clock cycles. The caller sets this hold so that each line level lasts at least the minimum time the memory needs, for example one microsecond. The three driven lines leave the block as one packed vector because the neighbouring pad logic decodes the bit positions.

Top module: `mwire_word_reader`

## Requirements
- R1: After reset, the line vector is 3'b000, busy and done are low, and the word output is zero.
- R2: Bit 0 of the line vector is the shift clock, bit 1 is the select and bit 2 is the serial command line to the memory. The memory's serial data comes back on its own input pin.
- R3: A transaction opens with four line levels: 000, then 010, then 011, then 010.
- R4: Three command bits follow: 1, 1, 0, which are the start bit and then the read opcode. Each bit is presented as {bit,1,0} and then clocked as {bit,1,1}.
- R5: Eight address bits follow with the most significant bit first, each presented and then clocked as in R4. A single 010 level comes after them.
- R6: Sixteen data bits follow, each as 011 and then 010. The data input is sampled at the end of each 010 level and shifted in most significant bit first.
- R7: The transaction closes with 000, 010, 000, 001. The line vector stays at 001 after completion until the next request.
- R8: Each of the 63 line levels lasts exactly H cycles. H is the hold value captured on the request cycle, and later changes to the hold input have no effect on a running transaction.
- R9: Busy rises the cycle after an accepted request and stays high for 63·H cycles. Done is a one-cycle pulse in the cycle busy falls, and the word output is valid from that cycle.
- R10: A request that arrives while busy is ignored. It changes neither the address, the hold value nor the timing of the running transaction.
- R11: A hold value of zero is treated as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle read request |
| addr_i | input | 8 | Word address, captured with the request |
| hold_i | input | HOLD_W | Cycles each line level is held |
| eep_ctl_o | output | 3 | Line vector: bit 0 clock, bit 1 select, bit 2 serial command |
| eep_dq_i | input | 1 | Serial data from the memory |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| word_o | output | 16 | Word read from the memory |

## Verification
The bench builds the block with HOLD_W = 3. This keeps hold values between 0 and 7, so every transaction fits in a few hundred cycles. It also lets the zero-hold floor be reached, and it leaves room to raise the hold input mid-transaction to show the captured value is kept. A behavioural memory model in the bench waits for the start bit, checks the opcode, and drives data after each rising clock. A wrong opcode, address or bit order therefore shows up in the returned word as well as in the recorded line trace.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned CMD_BITS  = 3;
  localparam int unsigned LINE_W    = 3;
  // Level counts per phase
  localparam int unsigned PRE_N     = 4;
  localparam int unsigned CMD_N     = 2 * CMD_BITS;
  localparam int unsigned ADR_N     = 2 * ADDR_W;
  localparam int unsigned GAP_N     = 1;
  localparam int unsigned DAT_N     = 2 * DATA_W;
  localparam int unsigned TAIL_N    = 4;
  localparam int unsigned CMD_BASE  = PRE_N;
  localparam int unsigned ADR_BASE  = CMD_BASE + CMD_N;
  localparam int unsigned GAP_BASE  = ADR_BASE + ADR_N;
  localparam int unsigned DAT_BASE  = GAP_BASE + GAP_N;
  localparam int unsigned TAIL_BASE = DAT_BASE + DAT_N;
  localparam int unsigned N_LEVELS  = TAIL_BASE + TAIL_N;
  localparam int unsigned STEP_W    = $clog2(N_LEVELS);
  localparam logic [CMD_BITS-1:0] READ_CMD = 3'b110;

  localparam logic [LINE_W-1:0] LV_OFF = 3'b000;
  localparam logic [LINE_W-1:0] LV_SEL = 3'b010;
  localparam logic [LINE_W-1:0] LV_SCK = 3'b011;
  localparam logic [LINE_W-1:0] LV_CLK = 3'b001;

  // Level for a (bit value, clock phase) pair with select high
  function automatic logic [LINE_W-1:0] sel_bit(input logic b, input logic ck);
    return {b, 1'b1, ck};
  endfunction

  // Line level driven during step idx of a transaction
  function automatic logic [LINE_W-1:0] level_of(input int idx, input logic [ADDR_W-1:0] a);
    int k;
    if (idx < int'(CMD_BASE)) begin
      case (idx)
        0:       return LV_OFF;
        2:       return LV_SCK;
        default: return LV_SEL;
      endcase
    end else if (idx < int'(ADR_BASE)) begin
      k = (idx - int'(CMD_BASE)) / 2;
      return sel_bit(READ_CMD[CMD_BITS-1-k], idx[0] ^ CMD_BASE[0]);
    end else if (idx < int'(GAP_BASE)) begin
      k = (idx - int'(ADR_BASE)) / 2;
      return sel_bit(a[ADDR_W-1-k], idx[0] ^ ADR_BASE[0]);
    end else if (idx < int'(DAT_BASE)) begin
      return LV_SEL;
    end else if (idx < int'(TAIL_BASE)) begin
      return ((idx - int'(DAT_BASE)) % 2 == 0) ? LV_SCK : LV_SEL;
    end else begin
      case (idx - int'(TAIL_BASE))
        1:       return LV_SEL;
        3:       return LV_CLK;
        default: return LV_OFF;
      endcase
    end
  endfunction

  // True for the clock-low level after which data-in is taken
  function automatic logic samples_at(input int idx);
    return (idx >= int'(DAT_BASE)) && (idx < int'(TAIL_BASE)) &&
           ((idx - int'(DAT_BASE)) % 2 == 1);
  endfunction
endpackage

// File: rtl/mwr_pacer.sv
module mwr_pacer #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [HOLD_W-1:0] hold_i,
  output logic [HOLD_W-1:0] hold_lat,
  output logic              step_end
);
  logic [HOLD_W-1:0] cnt;

  assign step_end = run && !load && (cnt == hold_lat - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_lat <= HOLD_W'(1);
      cnt      <= '0;
    end else if (load) begin
      hold_lat <= (hold_i == '0) ? HOLD_W'(1) : hold_i;
      cnt      <= '0;
    end else if (step_end) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_hold_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_lat != '0);
  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(hold_lat));
endmodule

// File: rtl/mwr_shifter.sv
module mwr_shifter #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              din,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (clear) word <= '0;
    else if (take)  word <= {word[DATA_W-2:0], din};
  end
endmodule

// File: rtl/mwr_seq.sv
module mwr_seq
  import mwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_end,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] step,
  output logic [LINE_W-1:0] lines,
  output logic              sample_evt
);
  localparam int LAST = int'(N_LEVELS) - 1;
  logic [ADDR_W-1:0] addr_lat;

  assign accept     = start_i && !busy;
  assign sample_evt = step_end && samples_at(int'(step));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step     <= '0;
      lines    <= LV_OFF;
      addr_lat <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        step     <= '0;
        addr_lat <= addr_i;
        lines    <= level_of(0, addr_i);
      end else if (step_end) begin
        if (int'(step) == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step  <= step + 1'b1;
          lines <= level_of(int'(step) + 1, addr_lat);
        end
      end
    end
  end

  assert_sample_clock_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (lines == LV_SEL));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_end_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lines == LV_CLK));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !step_end) |=> $stable(step));
  assert_step_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step) <= LAST);
endmodule

// File: rtl/mwire_word_reader.sv
module mwire_word_reader
  import mwr_pkg::*;
#(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        addr_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic [2:0]        eep_ctl_o,
  input  logic              eep_dq_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       word_o
);
  logic              accept, step_end, sample_evt, busy;
  logic [HOLD_W-1:0] hold_lat;
  logic [STEP_W-1:0] step;
  logic [LINE_W-1:0] lines;

  mwr_pacer #(.HOLD_W(HOLD_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy),
    .hold_i(hold_i), .hold_lat(hold_lat), .step_end(step_end)
  );

  mwr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .step_end(step_end), .accept(accept), .busy(busy), .done(done_o),
    .step(step), .lines(lines), .sample_evt(sample_evt)
  );

  mwr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(accept), .take(sample_evt),
    .din(eep_dq_i), .word(word_o)
  );

  assign eep_ctl_o = lines;
  assign busy_o    = busy;

  // Run-length tracker for the hold-time property
  logic [LINE_W-1:0] lines_q;
  logic              busy_q;
  logic [HOLD_W:0]   run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= LV_OFF;
      busy_q  <= 1'b0;
      run_len <= (HOLD_W+1)'(1);
    end else begin
      lines_q <= lines;
      busy_q  <= busy;
      if (lines != lines_q || !busy_q) run_len <= (HOLD_W+1)'(1);
      else if (run_len != '1)          run_len <= run_len + 1'b1;
    end
  end

  assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && busy && lines != lines_q) |-> (run_len == {1'b0, hold_lat}));
endmodule

// File: tb/sim_mwire_word_reader.sv
module sim_mwire_word_reader;
  localparam int HW = 3;
  localparam int NV = 6;
  localparam int NL = 63;
  // {addr, hold}
  localparam logic [10:0] VEC [NV] = '{
    {8'h00, 3'd1}, {8'hFF, 3'd2}, {8'hA5, 3'd3},
    {8'h5A, 3'd0}, {8'h21, 3'd4}, {8'h80, 3'd7}
  };

  logic clk = 0, rst_n = 0, start_i = 0, dq = 0;
  logic [7:0] addr_i = 0;
  logic [HW-1:0] hold_i = 0;
  logic [2:0] ctl;
  logic busy_o, done_o;
  logic [15:0] word_o;
  int checks = 0, errors = 0;
  logic [2:0] exp_v [0:79];
  logic [2:0] obs_v [0:79];
  int obs_l [0:79];
  int ne, no, busy_cyc;

  always #5 clk = ~clk;

  mwire_word_reader #(.HOLD_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .hold_i(hold_i), .eep_ctl_o(ctl), .eep_dq_i(dq), .busy_o(busy_o),
    .done_o(done_o), .word_o(word_o)
  );

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {a ^ 8'h3C, a + 8'h5B};
  endfunction

  // Behavioural memory: waits for start bit, takes opcode and address
  logic started = 0;
  int bitn = 0;
  logic [9:0] cmd = 0;
  logic [15:0] rdw = 0;
  always @(posedge ctl[0] or negedge ctl[1]) begin
    if (!ctl[1]) begin
      started = 0; bitn = 0; dq = 0;
    end else if (!started) begin
      if (ctl[2]) begin started = 1; bitn = 0; end
    end else if (bitn < 10) begin
      cmd = {cmd[8:0], ctl[2]};
      bitn++;
      if (bitn == 10) rdw = (cmd[9:8] == 2'b10) ? mem_word(cmd[7:0]) : 16'h0000;
    end else if (bitn < 26) begin
      dq = rdw[25 - bitn];
      bitn++;
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] v);
    exp_v[ne] = v; ne++;
  endtask

  task automatic build_exp(input logic [7:0] a);
    logic [10:0] bits;
    ne = 0;
    push(3'b000); push(3'b010); push(3'b011); push(3'b010);
    bits = {3'b110, a};
    for (int i = 10; i >= 0; i--) begin
      push({bits[i], 2'b10}); push({bits[i], 2'b11});
    end
    push(3'b010);
    for (int i = 0; i < 16; i++) begin push(3'b011); push(3'b010); end
    push(3'b000); push(3'b010); push(3'b000); push(3'b001);
  endtask

  task automatic run_txn(input logic [7:0] a, input int h, input bit poke);
    logic [2:0] last;
    int eff, bad_v, bad_l;
    eff = (h == 0) ? 1 : h;
    build_exp(a);
    no = 0; busy_cyc = 0; last = 0;
    @(negedge clk); start_i = 1; addr_i = a; hold_i = HW'(h);
    @(negedge clk); start_i = 0;
    while (busy_o && busy_cyc < 5000) begin
      if ((no == 0 || ctl != last) && no < 80) begin
        obs_v[no] = ctl; obs_l[no] = 1; no++;
      end else if (no > 0) obs_l[no-1]++;
      last = ctl; busy_cyc++;
      if (poke && busy_cyc == 20) begin start_i = 1; addr_i = ~a; hold_i = HW'(h + 3); end
      if (poke && busy_cyc == 21) start_i = 0;
      @(negedge clk);
    end
    chk("R9 busy length", busy_cyc, NL * eff);
    chk("R9 done at busy fall", done_o, 1);
    chk("R6 word value", word_o, mem_word(a));
    chk("R7 clock left high", ctl, 3'b001);
    chk("R3 R4 R5 R6 R7 level count", no, NL);
    bad_v = -1; bad_l = -1;
    for (int i = 0; i < NL && i < no; i++) begin
      if (bad_v < 0 && obs_v[i] !== exp_v[i]) bad_v = i;
      if (bad_l < 0 && obs_l[i] != eff) bad_l = i;
    end
    chk("R2 R3 R4 R5 R7 level order (first bad index)", bad_v, -1);
    chk("R8 R11 level hold (first bad index)", bad_l, -1);
    @(negedge clk);
    chk("R9 done single cycle", done_o, 0);
    chk("R7 clock stays high", ctl, 3'b001);
    hold_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lines", ctl, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 word", word_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", ctl, 0);
    for (int v = 0; v < NV; v++)
      run_txn(VEC[v][10:3], int'(VEC[v][2:0]), 1'b0);
    // R11 zero hold acts as one (vector 3 also covers it)
    run_txn(8'h33, 0, 1'b0);
    // R10 request during busy ignored; R8 hold captured at request
    run_txn(8'hC6, 2, 1'b1);
    // back-to-back request right after done
    run_txn(8'h01, 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule